// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This unit sits in a UART register file. It gathers the seven interrupt causes of one channel, masks each with its own enable bit, and picks the most urgent pending cause. The result is an 8-bit identification value that software reads to find which service routine to run. Some causes are plain levels owned by neighbouring logic: line-status error, receive timeout, modem-status change, and the receive FIFO fill level measured against a trigger depth. Others are event flags that this unit keeps itself: transmit holding empty, flow-control or special character match, and a rising edge on the CTS or RTS line. Each flag is cleared by its own rule.

Software reads the identification value by pulsing `isr_rd`. The value is captured at the clock edge of that pulse and held on `isr_rdata` until the next read. Only the cause that the captured value reports has its clear-on-read rule applied. The character-match and flow-edge causes depend on an enhanced-feature enable input and are ignored while it is low. The FIFO trigger depth is a single selection that both the receive-trigger and transmit-trigger write strobes update, so the last write decides the depth for both directions. A registered interrupt request output follows the presence of any enabled pending cause.

Top module: `uart_irq_id`

## Requirements
- R1: After reset `isr_rdata` is 8'h01, `irq` is 0, `trig_level` is 1 and `xchar_is_xoff` is 0.
- R2: `isr_rdata[5:0]` reports the winning cause with these codes, listed from highest to lowest priority: line status 6'h06, receive data ready 6'h04, receive timeout 6'h0C, transmit holding empty 6'h02, modem status 6'h00, character match 6'h10, flow edge 6'h20. It reads 6'h01 when no cause is pending.
- R3: `isr_rdata[7:6]` is 2'b11 when `fifo_en` was 1 at the read edge and 2'b00 otherwise.
- R4: An `ier_wr` pulse loads `ier_wdata`, whose bit i enables the cause at priority index i (0 for line status up to 6 for flow edge). A disabled cause is never reported, and its flag is kept, so re-enabling it reports it.
- R5: While `efr_enh` is 0, the character-match and flow-edge causes are neither set nor reported, and `xchar_is_xoff` does not change.
- R6: A low-to-high change on `cts_line` or on `rts_line` sets the flow-edge flag. A falling change does not set it. A read that reports the flag clears it.
- R7: An Xon or Xoff match sets the character-match flag, and only a read that reports the flag clears it. `xchar_is_xoff` is 1 after an Xoff match and 0 after an Xon match.
- R8: A special-character match sets the character-match flag. That flag clears on a read that reports it, or on the next `rx_char` pulse.
- R9: Receive data ready is pending while `rx_count` is at or above the trigger depth. The depth is chosen by `trig_sel` (0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14) and is loaded by either `trig_rx_wr` or `trig_tx_wr`. The last write applies to both directions and is shown on `trig_level`.
- R10: A read captures the value present at its clock edge. A cause that arrives in that same cycle does not change the captured value, and causes that were not reported are not cleared.
- R11: `irq` is 1 one cycle after any enabled cause is pending, and it returns to 0 one cycle after none is pending.
- R12: A `thre_set` pulse sets the transmit-holding-empty flag. The flag clears on a `thr_wr` pulse or on a read that reports it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Load the per-cause enable bits |
| ier_wdata | input | 7 | Enable bits, bit i for priority index i |
| efr_enh | input | 1 | Enhanced-feature enable level |
| fifo_en | input | 1 | FIFO enable level |
| trig_rx_wr | input | 1 | Receive-side trigger select write |
| trig_tx_wr | input | 1 | Transmit-side trigger select write |
| trig_sel | input | 2 | Trigger depth selection |
| rx_count | input | CNT_W | Receive FIFO fill count |
| ls_err | input | 1 | Line-status error level |
| rx_tmo | input | 1 | Receive timeout level |
| msr_chg | input | 1 | Modem-status change level |
| thre_set | input | 1 | Transmit holding became empty |
| thr_wr | input | 1 | Transmit holding register written |
| xon_hit | input | 1 | Xon character matched |
| xoff_hit | input | 1 | Xoff character matched |
| spec_hit | input | 1 | Special character matched |
| rx_char | input | 1 | A character was received |
| cts_line | input | 1 | CTS line level |
| rts_line | input | 1 | RTS line level |
| isr_rd | input | 1 | Read of the identification value |
| isr_rdata | output | 8 | Captured identification value |
| irq | output | 1 | Registered interrupt request |
| trig_level | output | 4 | Current trigger depth |
| xchar_is_xoff | output | 1 | Last flow character was Xoff |

## Verification
A wrong event flag does not show at the ports until later. It appears on `irq` one cycle after the flag itself is wrong, and on `isr_rdata` only at the next read. For that reason the bench reads the identification value right after each stimulus and again after each clear, and it compares `irq` against its reference model on every clock. A stale trigger selection shows on `trig_level` at once, but in the reported code only when `rx_count` lies between the old depth and the new one, so the bench places the count on both sides of the new boundary.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int SRC_N   = 7;
    localparam int CODE_W  = 6;
    localparam int LVL_W   = 4;

    localparam int IDX_LINE   = 0;
    localparam int IDX_RXDATA = 1;
    localparam int IDX_RXTMO  = 2;
    localparam int IDX_TXMT   = 3;
    localparam int IDX_MODEM  = 4;
    localparam int IDX_CMATCH = 5;
    localparam int IDX_FEDGE  = 6;

    localparam logic [CODE_W-1:0] CODE_NONE = 6'b000001;

    // identification code per priority index
    function automatic logic [CODE_W-1:0] src_code(input int idx);
        case (idx)
            IDX_LINE:   return 6'b000110;
            IDX_RXDATA: return 6'b000100;
            IDX_RXTMO:  return 6'b001100;
            IDX_TXMT:   return 6'b000010;
            IDX_MODEM:  return 6'b000000;
            IDX_CMATCH: return 6'b010000;
            default:    return 6'b100000;
        endcase
    endfunction

    // shared trigger depth table
    function automatic logic [LVL_W-1:0] trig_depth(input logic [1:0] sel);
        case (sel)
            2'd0:    return 4'd1;
            2'd1:    return 4'd4;
            2'd2:    return 4'd8;
            default: return 4'd14;
        endcase
    endfunction

    typedef struct packed {
        logic thre;
        logic cm;
        logic cm_spec;
        logic xoff_last;
        logic fe;
        logic cts_prev;
        logic rts_prev;
    } flag_st_t;

    typedef struct packed {
        logic [1:0] sel;
    } trig_st_t;

    typedef struct packed {
        logic [SRC_N-1:0] en;
        logic [7:0]       rdata;
        logic             irq;
    } top_st_t;
endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_wr,
    input  logic             tx_wr,
    input  logic [1:0]       sel_in,
    input  logic [CNT_W-1:0] rx_count,
    output logic [LVL_W-1:0] level,
    output logic             rx_ready
);
    localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

    trig_st_t st_d, st_q;
    logic [CMP_W-1:0] cnt_ext, lvl_ext;

    always_comb begin
        st_d = st_q;
        if (rx_wr || tx_wr) begin
            st_d.sel = sel_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level   = trig_depth(st_q.sel);
    assign cnt_ext = CMP_W'(rx_count);
    assign lvl_ext = CMP_W'(level);
    assign rx_ready = (cnt_ext >= lvl_ext);
endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enh,
    input  logic thre_set,
    input  logic thr_wr,
    input  logic thre_clr,
    input  logic xon_hit,
    input  logic xoff_hit,
    input  logic spec_hit,
    input  logic rx_char,
    input  logic cm_clr,
    input  logic cts_line,
    input  logic rts_line,
    input  logic fe_clr,
    output logic thre_flag,
    output logic cm_flag,
    output logic xoff_last,
    output logic fe_flag
);
    flag_st_t st_d, st_q;
    logic     line_rise;
    logic     any_match;

    always_comb begin
        st_d      = st_q;
        line_rise = (cts_line && !st_q.cts_prev) || (rts_line && !st_q.rts_prev);
        any_match = xon_hit || xoff_hit || spec_hit;

        // transmit holding empty
        st_d.thre = (st_q.thre && !(thr_wr || thre_clr)) || thre_set;

        // character match: read clear, or auto clear for special chars
        if (st_q.cm && (cm_clr || (st_q.cm_spec && rx_char))) begin
            st_d.cm = 1'b0;
        end
        if (enh && any_match) begin
            st_d.cm      = 1'b1;
            st_d.cm_spec = spec_hit;
        end
        if (enh && xoff_hit) begin
            st_d.xoff_last = 1'b1;
        end else if (enh && xon_hit) begin
            st_d.xoff_last = 1'b0;
        end

        // flow line rising edge
        st_d.fe       = (st_q.fe && !fe_clr) || (enh && line_rise);
        st_d.cts_prev = cts_line;
        st_d.rts_prev = rts_line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign thre_flag = st_q.thre;
    assign cm_flag   = st_q.cm;
    assign xoff_last = st_q.xoff_last;
    assign fe_flag   = st_q.fe;
endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
    import uart_irq_pkg::*;
(
    input  logic [SRC_N-1:0]  req,
    output logic [SRC_N-1:0]  grant,
    output logic              any,
    output logic [CODE_W-1:0] code
);
    logic [SRC_N:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < SRC_N; i++) begin : g_prio
        assign grant[i]     = req[i] && !blocked[i];
        assign blocked[i+1] = blocked[i] || req[i];
    end

    assign any = blocked[SRC_N];

    always_comb begin
        code = CODE_NONE;
        for (int i = 0; i < SRC_N; i++) begin
            if (grant[i]) begin
                code = src_code(i);
            end
        end
    end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [6:0]       ier_wdata,
    input  logic             efr_enh,
    input  logic             fifo_en,
    input  logic             trig_rx_wr,
    input  logic             trig_tx_wr,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             ls_err,
    input  logic             rx_tmo,
    input  logic             msr_chg,
    input  logic             thre_set,
    input  logic             thr_wr,
    input  logic             xon_hit,
    input  logic             xoff_hit,
    input  logic             spec_hit,
    input  logic             rx_char,
    input  logic             cts_line,
    input  logic             rts_line,
    input  logic             isr_rd,
    output logic [7:0]       isr_rdata,
    output logic             irq,
    output logic [3:0]       trig_level,
    output logic             xchar_is_xoff
);
    top_st_t           st_d, st_q;
    logic              rx_ready;
    logic              thre_flag, cm_flag, fe_flag, xoff_last;
    logic [SRC_N-1:0]  cond, gate, req, grant;
    logic [SRC_N-1:0]  en_view;
    logic              any_pend;
    logic [CODE_W-1:0] win_code;
    logic [7:0]        isr_now;
    logic              thre_clr, cm_clr, fe_clr;

    uart_irq_trig #(.CNT_W(CNT_W)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_wr    (trig_rx_wr),
        .tx_wr    (trig_tx_wr),
        .sel_in   (trig_sel),
        .rx_count (rx_count),
        .level    (trig_level),
        .rx_ready (rx_ready)
    );

    uart_irq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .enh       (efr_enh),
        .thre_set  (thre_set),
        .thr_wr    (thr_wr),
        .thre_clr  (thre_clr),
        .xon_hit   (xon_hit),
        .xoff_hit  (xoff_hit),
        .spec_hit  (spec_hit),
        .rx_char   (rx_char),
        .cm_clr    (cm_clr),
        .cts_line  (cts_line),
        .rts_line  (rts_line),
        .fe_clr    (fe_clr),
        .thre_flag (thre_flag),
        .cm_flag   (cm_flag),
        .xoff_last (xoff_last),
        .fe_flag   (fe_flag)
    );

    always_comb begin
        cond             = '0;
        cond[IDX_LINE]   = ls_err;
        cond[IDX_RXDATA] = rx_ready;
        cond[IDX_RXTMO]  = rx_tmo;
        cond[IDX_TXMT]   = thre_flag;
        cond[IDX_MODEM]  = msr_chg;
        cond[IDX_CMATCH] = cm_flag;
        cond[IDX_FEDGE]  = fe_flag;

        gate             = '1;
        gate[IDX_CMATCH] = efr_enh;
        gate[IDX_FEDGE]  = efr_enh;
    end

    assign req = cond & st_q.en & gate;

    uart_irq_arb u_arb (
        .req   (req),
        .grant (grant),
        .any   (any_pend),
        .code  (win_code)
    );

    assign isr_now  = {fifo_en, fifo_en, win_code};
    assign thre_clr = isr_rd && grant[IDX_TXMT];
    assign cm_clr   = isr_rd && grant[IDX_CMATCH];
    assign fe_clr   = isr_rd && grant[IDX_FEDGE];

    always_comb begin
        st_d     = st_q;
        st_d.irq = any_pend;
        if (ier_wr) begin
            st_d.en = ier_wdata;
        end
        if (isr_rd) begin
            st_d.rdata = isr_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.rdata <= {2'b00, CODE_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign en_view       = st_q.en;
    assign isr_rdata     = st_q.rdata;
    assign irq           = st_q.irq;
    assign xchar_is_xoff = xoff_last;
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       isr_rd,
    input logic [7:0] isr_rdata,
    input logic       irq,
    input logic       efr_enh,
    input logic       thre_set,
    input logic       thre_flag,
    input logic       fe_flag,
    input logic [6:0] grant,
    input logic [6:0] en_view
);
    // R2
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr_rdata[5:0] inside {6'h01, 6'h06, 6'h04, 6'h0C, 6'h02, 6'h00, 6'h10, 6'h20});

    // R3
    fifo_bits_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr_rdata[7] == isr_rdata[6]);

    // R5
    enh_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && !efr_enh) |=> (isr_rdata[5:4] == 2'b00));

    // R6
    edge_needs_enh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fe_flag) |-> $past(efr_enh));

    // R11
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thre_flag && en_view[3]) |=> irq);

    // R12
    thre_read_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && grant[3] && !thre_set) |=> !thre_flag);
endmodule

bind uart_irq_id uart_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .isr_rd    (isr_rd),
    .isr_rdata (isr_rdata),
    .irq       (irq),
    .efr_enh   (efr_enh),
    .thre_set  (thre_set),
    .thre_flag (thre_flag),
    .fe_flag   (fe_flag),
    .grant     (grant),
    .en_view   (en_view)
);

// File: tb/uart_irq_id_test.sv
`timescale 1ns/1ps
module uart_irq_id_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ier_wr = 0, efr_enh = 0, fifo_en = 0;
    logic [6:0] ier_wdata = '0;
    logic       trig_rx_wr = 0, trig_tx_wr = 0;
    logic [1:0] trig_sel = '0;
    logic [4:0] rx_count = '0;
    logic       ls_err = 0, rx_tmo = 0, msr_chg = 0;
    logic       thre_set = 0, thr_wr = 0;
    logic       xon_hit = 0, xoff_hit = 0, spec_hit = 0, rx_char = 0;
    logic       cts_line = 0, rts_line = 0, isr_rd = 0;
    logic [7:0] isr_rdata;
    logic       irq;
    logic [3:0] trig_level;
    logic       xchar_is_xoff;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_irq_id uut (.*);

    // reference model state
    logic [6:0] m_en;
    int         m_sel;
    bit         m_thre, m_cm, m_spec, m_xoff, m_fe, m_pc, m_pr, m_irq;
    logic [7:0] m_rdata;

    function automatic int depth_of(int s);
        if (s == 0) return 1;
        if (s == 1) return 4;
        if (s == 2) return 8;
        return 14;
    endfunction

    function automatic logic [5:0] code_of(int w);
        case (w)
            0: return 6'h06;
            1: return 6'h04;
            2: return 6'h0C;
            3: return 6'h02;
            4: return 6'h00;
            5: return 6'h10;
            6: return 6'h20;
            default: return 6'h01;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_sel = 0; m_thre = 0; m_cm = 0; m_spec = 0; m_xoff = 0;
            m_fe = 0; m_pc = 0; m_pr = 0; m_irq = 0; m_rdata = 8'h01;
        end else begin
            logic [6:0] pend;
            int         win;
            bit         rise;
            pend[0] = ls_err;
            pend[1] = (int'(rx_count) >= depth_of(m_sel));
            pend[2] = rx_tmo;
            pend[3] = m_thre;
            pend[4] = msr_chg;
            pend[5] = m_cm && efr_enh;
            pend[6] = m_fe && efr_enh;
            pend = pend & m_en;
            win = -1;
            for (int i = 6; i >= 0; i--) if (pend[i]) win = i;
            m_irq = (pend != 0);
            if (isr_rd) m_rdata = {fifo_en, fifo_en, code_of(win)};
            if (thr_wr || (isr_rd && win == 3)) m_thre = 0;
            if (thre_set) m_thre = 1;
            if ((isr_rd && win == 5) || (m_spec && rx_char)) m_cm = 0;
            if (efr_enh && (xon_hit || xoff_hit || spec_hit)) begin
                m_cm = 1; m_spec = spec_hit;
            end
            if (efr_enh && xoff_hit) m_xoff = 1;
            else if (efr_enh && xon_hit) m_xoff = 0;
            rise = (cts_line && !m_pc) || (rts_line && !m_pr);
            if (isr_rd && win == 6) m_fe = 0;
            if (efr_enh && rise) m_fe = 1;
            m_pc = cts_line; m_pr = rts_line;
            if (ier_wr) m_en = ier_wdata;
            if (trig_rx_wr || trig_tx_wr) m_sel = int'(trig_sel);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R10 model rdata", isr_rdata, m_rdata);
            check("R11 model irq", irq, m_irq);
            check("R9 model level", trig_level, depth_of(m_sel));
            check("R7 model xoff", xchar_is_xoff, m_xoff);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_exp(input string tag, input logic [7:0] exp);
        isr_rd = 1;
        @(negedge clk);
        isr_rd = 0;
        check(tag, isr_rdata, exp);
    endtask

    task automatic pulse_thre();
        thre_set = 1; step(1); thre_set = 0;
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        // R1
        check("R1 reset rdata", isr_rdata, 8'h01);
        check("R1 reset irq", irq, 0);
        check("R1 reset level", trig_level, 1);
        check("R1 reset xoff", xchar_is_xoff, 0);

        ier_wr = 1; ier_wdata = 7'h7F; step(1); ier_wr = 0;

        // R12 read clear and write clear
        pulse_thre();
        read_exp("R12 thre reported", 8'h02);
        read_exp("R12 thre cleared by read", 8'h01);
        pulse_thre();
        thr_wr = 1; step(1); thr_wr = 0;
        read_exp("R12 thre cleared by write", 8'h01);

        // R2 priority walk
        ls_err = 1; rx_tmo = 1; msr_chg = 1; rx_count = 5'd1;
        pulse_thre();
        read_exp("R2 line status wins", 8'h06);
        ls_err = 0;
        read_exp("R2 rx data next", 8'h04);
        rx_count = 0;
        read_exp("R2 timeout next", 8'h0C);
        rx_tmo = 0;
        read_exp("R2 thre next", 8'h02);
        read_exp("R2 modem next", 8'h00);
        msr_chg = 0;
        read_exp("R2 none", 8'h01);

        // R3 fifo bits
        fifo_en = 1; msr_chg = 1;
        read_exp("R3 fifo on modem", 8'hC0);
        msr_chg = 0;
        read_exp("R3 fifo on none", 8'hC1);
        fifo_en = 0;

        // R4 per-source enable
        ier_wr = 1; ier_wdata = 7'h77; step(1); ier_wr = 0;
        pulse_thre();
        read_exp("R4 disabled not reported", 8'h01);
        step(1);
        check("R4 disabled no irq", irq, 0);
        ier_wr = 1; ier_wdata = 7'h7F; step(1); ier_wr = 0;
        read_exp("R4 kept after re-enable", 8'h02);

        // R9 trigger table shared by both strobes
        trig_rx_wr = 1; trig_sel = 2; step(1); trig_rx_wr = 0;
        check("R9 level 8", trig_level, 8);
        rx_count = 7;
        read_exp("R9 below depth", 8'h01);
        rx_count = 8;
        read_exp("R9 at depth", 8'h04);
        trig_tx_wr = 1; trig_sel = 3; step(1); trig_tx_wr = 0;
        check("R9 tx write sets 14", trig_level, 14);
        read_exp("R9 tx write applies to rx", 8'h01);
        rx_count = 0;

        // R5 enhanced gating
        xoff_hit = 1; cts_line = 1; step(1); xoff_hit = 0;
        read_exp("R5 gated off", 8'h01);
        check("R5 xoff unchanged", xchar_is_xoff, 0);
        efr_enh = 1; step(1);
        read_exp("R5 no stale edge", 8'h01);

        // R7 xon/xoff
        xoff_hit = 1; step(1); xoff_hit = 0;
        read_exp("R7 xoff reported", 8'h10);
        check("R7 xoff recorded", xchar_is_xoff, 1);
        read_exp("R7 cleared by read", 8'h01);
        xon_hit = 1; step(1); xon_hit = 0;
        check("R7 xon recorded", xchar_is_xoff, 0);
        rx_char = 1; step(1); rx_char = 0;
        read_exp("R7 not auto cleared", 8'h10);
        read_exp("R7 cleared", 8'h01);

        // R8 special char
        spec_hit = 1; step(1); spec_hit = 0;
        rx_char = 1; step(1); rx_char = 0;
        read_exp("R8 auto cleared", 8'h01);
        spec_hit = 1; step(1); spec_hit = 0;
        read_exp("R8 reported", 8'h10);
        read_exp("R8 read cleared", 8'h01);

        // R6 flow edges
        cts_line = 0; step(1);
        read_exp("R6 falling ignored", 8'h01);
        cts_line = 1; step(1);
        read_exp("R6 cts rise", 8'h20);
        read_exp("R6 cleared", 8'h01);
        rts_line = 1; step(1);
        read_exp("R6 rts rise", 8'h20);
        read_exp("R6 rts cleared", 8'h01);
        rts_line = 0;

        // R10 capture at read edge, clear only reported
        cts_line = 0; step(1); cts_line = 1; step(1);
        isr_rd = 1; thre_set = 1; step(1); isr_rd = 0; thre_set = 0;
        check("R10 late source not captured", isr_rdata, 8'h20);
        read_exp("R10 late source next", 8'h02);
        read_exp("R10 all clear", 8'h01);
        cts_line = 0; step(1); cts_line = 1; step(1);
        msr_chg = 1;
        pulse_thre();
        read_exp("R10 thre first", 8'h02);
        read_exp("R10 modem over edge", 8'h00);
        msr_chg = 0;
        read_exp("R10 edge kept", 8'h20);
        read_exp("R10 done", 8'h01);

        // R11 irq timing
        step(2);
        thre_set = 1; step(1); thre_set = 0;
        check("R11 irq not yet", irq, 0);
        step(1);
        check("R11 irq raised", irq, 1);
        read_exp("R11 read clears", 8'h02);
        check("R11 irq one more cycle", irq, 1);
        step(1);
        check("R11 irq dropped", irq, 0);

        step(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: all requirements, actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule